// File: doc/BRIEF.md
# Banked Memory Mapper with ROM Overlay

This block translates a 16-bit processor address into a location in a larger physical memory. The address space is split into four 16K windows, chosen by the two top address bits. Each window is backed by one of eight 16K RAM pages. The first window and the last window can each show a ROM for reads, and each has its own enable. Writes never reach a ROM. They always land in the RAM page that sits under the window.

A single configuration register holds the two ROM controls and a 3-bit page arrangement. The arrangement decides which RAM pages fill the four windows. The register is loaded through a write port and takes effect on the next clock. All translation is combinational from the registered value.

A second, independent port serves video fetches. It always resolves into the four base RAM pages and never looks at the processor's mapping. The memories themselves sit outside the block. Only the selects, page numbers and offsets come out.

Top module: `bank_mapper`

## Requirements
- R1: After synchronous reset both ROMs are enabled and arrangement 0 is active, so a read in window 0 selects the lower ROM and a read in window 3 selects the upper ROM.
- R2: The window is cpu_addr[15:14], and ram_offset and rom_offset both equal cpu_addr[13:0].
- R3: A read (cpu_rd=1, cpu_wr=0) in window 0 while configuration bit 0 is 0 asserts rom_lo_sel only. If bit 0 is 1, the read goes to RAM.
- R4: A read in window 3 while configuration bit 1 is 0 asserts rom_hi_sel only. If bit 1 is 1, the read goes to RAM.
- R5: Any write asserts ram_sel and neither ROM select, even in a window where a ROM is enabled. When both strobes are high, the write takes priority.
- R6: Configuration bits 4:2 hold the arrangement. Arrangement 1 puts page 7 in window 3 and leaves pages 0, 1, 2 in windows 0 to 2.
- R7: Arrangements 4 to 7 put the page whose number equals the arrangement into window 1. Windows 0, 2 and 3 keep pages 0, 2 and 3.
- R8: Arrangements 0, 2 and 3 map windows 0 to 3 onto pages 0 to 3.
- R9: vid_page equals vid_addr[15:14] and vid_offset equals vid_addr[13:0], whatever the configuration and processor activity.
- R10: A configuration write is captured on the rising clock edge. An access in the same cycle as the write still uses the old configuration. Without cfg_we the configuration holds.
- R11: With neither strobe asserted, ram_sel, rom_lo_sel and rom_hi_sel are all 0.
- R12: With both ROMs disabled, a read and a write to the same address give the same ram_page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_data | input | 8 | Configuration value: bit0 lower-ROM off, bit1 upper-ROM off, bits 4:2 arrangement |
| cpu_addr | input | 16 | Processor address |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_wr | input | 1 | Processor write strobe |
| ram_sel | output | 1 | Access goes to RAM |
| ram_page | output | 3 | Physical RAM page for the current window |
| ram_offset | output | 14 | Offset within the RAM page |
| rom_lo_sel | output | 1 | Read served by the lower ROM |
| rom_hi_sel | output | 1 | Read served by the upper ROM |
| rom_offset | output | 14 | Offset within the selected ROM |
| vid_addr | input | 16 | Video fetch address |
| vid_page | output | 2 | Base RAM page for the video fetch |
| vid_offset | output | 14 | Offset within the video page |

## Verification
Three things can happen in one cycle: a configuration write, a processor access, and a video fetch. The bench drives all three together, with the configuration changing about one cycle in eight. It checks that the processor's selects and page still follow the old configuration in the write cycle and the new one in the following cycle. It also checks that the video outputs never change with configuration or processor traffic. A behavioural model updated at each clock edge gives the expected values, and every output is compared on every cycle.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;
  localparam int unsigned ARR_W   = 3;
  localparam int unsigned LO_BIT  = 0;
  localparam int unsigned HI_BIT  = 1;
  localparam int unsigned ARR_LSB = 2;

  typedef struct packed {
    logic             lo_off;
    logic             hi_off;
    logic [ARR_W-1:0] arr;
  } map_cfg_t;
endpackage

// File: rtl/bank_cfg_reg.sv
module bank_cfg_reg
  import bank_mapper_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [4:0] data,
  output map_cfg_t   cfg
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (we) begin
      cfg.lo_off <= data[LO_BIT];
      cfg.hi_off <= data[HI_BIT];
      cfg.arr    <= data[ARR_LSB +: ARR_W];
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(cfg));
  assert_reset_R1: assert property (@(posedge clk)
    $fell(rst) |-> (cfg.lo_off == 1'b0 && cfg.hi_off == 1'b0 && cfg.arr == '0));
endmodule

// File: rtl/bank_window_map.sv
module bank_window_map
  import bank_mapper_pkg::*;
#(
  parameter int unsigned WIN_W  = 2,
  parameter int unsigned PAGE_W = 3,
  localparam int unsigned NUM_WIN = 1 << WIN_W
) (
  input  logic [ARR_W-1:0]                arr,
  output logic [NUM_WIN-1:0][PAGE_W-1:0]  page_tbl
);
  localparam int unsigned TOP_PAGE = 2 * NUM_WIN - 1;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    always_comb begin
      page_tbl[w] = PAGE_W'(w);
      if (w == NUM_WIN - 1 && arr == ARR_W'(1))
        page_tbl[w] = PAGE_W'(TOP_PAGE);
      if (w == 1 && arr[ARR_W-1])
        page_tbl[w] = PAGE_W'(arr);
    end
  end
endmodule

// File: rtl/bank_rom_overlay.sv
module bank_rom_overlay #(
  parameter int unsigned WIN_W = 2,
  localparam int unsigned NUM_WIN = 1 << WIN_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIN_W-1:0] win,
  input  logic             rd,
  input  logic             wr,
  input  logic             lo_en,
  input  logic             hi_en,
  output logic             ram_sel,
  output logic             rom_lo_sel,
  output logic             rom_hi_sel
);
  logic rd_only;

  always_comb begin
    rd_only    = rd && !wr;
    rom_lo_sel = rd_only && lo_en && (win == '0);
    rom_hi_sel = rd_only && hi_en && (win == WIN_W'(NUM_WIN - 1));
    ram_sel    = wr || (rd_only && !rom_lo_sel && !rom_hi_sel);
  end

  assert_one_target_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ram_sel, rom_lo_sel, rom_hi_sel}));
  assert_write_ram_R5: assert property (@(posedge clk) disable iff (rst)
    wr |-> (ram_sel && !rom_lo_sel && !rom_hi_sel));
  assert_lo_window_R3: assert property (@(posedge clk) disable iff (rst)
    rom_lo_sel |-> (win == '0 && rd));
  assert_hi_window_R4: assert property (@(posedge clk) disable iff (rst)
    rom_hi_sel |-> (win == WIN_W'(NUM_WIN - 1) && rd));
  assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
    (!rd && !wr) |-> !(ram_sel || rom_lo_sel || rom_hi_sel));
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bank_mapper_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned WIN_W  = 2,
  parameter int unsigned PAGE_W = 3,
  localparam int unsigned OFFS_W  = ADDR_W - WIN_W,
  localparam int unsigned NUM_WIN = 1 << WIN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_data,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic              ram_sel,
  output logic [PAGE_W-1:0] ram_page,
  output logic [OFFS_W-1:0] ram_offset,
  output logic              rom_lo_sel,
  output logic              rom_hi_sel,
  output logic [OFFS_W-1:0] rom_offset,
  input  logic [ADDR_W-1:0] vid_addr,
  output logic [WIN_W-1:0]  vid_page,
  output logic [OFFS_W-1:0] vid_offset
);
  map_cfg_t                        cfg;
  logic [NUM_WIN-1:0][PAGE_W-1:0]  page_tbl;
  logic [WIN_W-1:0]                cpu_win;
  logic [2:0]                      unused_cfg_hi;

  assign unused_cfg_hi = cfg_data[7:5];
  assign cpu_win       = cpu_addr[ADDR_W-1 -: WIN_W];

  bank_cfg_reg u_cfg (
    .clk  (clk),
    .rst  (rst),
    .we   (cfg_we),
    .data (cfg_data[4:0]),
    .cfg  (cfg)
  );

  bank_window_map #(.WIN_W(WIN_W), .PAGE_W(PAGE_W)) u_map (
    .arr      (cfg.arr),
    .page_tbl (page_tbl)
  );

  bank_rom_overlay #(.WIN_W(WIN_W)) u_ovl (
    .clk        (clk),
    .rst        (rst),
    .win        (cpu_win),
    .rd         (cpu_rd),
    .wr         (cpu_wr),
    .lo_en      (!cfg.lo_off),
    .hi_en      (!cfg.hi_off),
    .ram_sel    (ram_sel),
    .rom_lo_sel (rom_lo_sel),
    .rom_hi_sel (rom_hi_sel)
  );

  assign ram_page   = page_tbl[cpu_win];
  assign ram_offset = cpu_addr[OFFS_W-1:0];
  assign rom_offset = cpu_addr[OFFS_W-1:0];
  assign vid_page   = vid_addr[ADDR_W-1 -: WIN_W];
  assign vid_offset = vid_addr[OFFS_W-1:0];

  assert_mid_windows_R7: assert property (@(posedge clk) disable iff (rst)
    (cpu_win == 2'd2) |-> (ram_page == 3'd2));
  assert_video_follow_R9: assert property (@(posedge clk) disable iff (rst)
    $stable(vid_addr) |-> $stable(vid_page));
endmodule

// File: tb/sim_bank_mapper.sv
`timescale 1ns/1ps
module sim_bank_mapper;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_data = '0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [15:0] vid_addr = '0;
  logic        ram_sel, rom_lo_sel, rom_hi_sel;
  logic [2:0]  ram_page;
  logic [13:0] ram_offset, rom_offset, vid_offset;
  logic [1:0]  vid_page;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int m_lo_en = 1, m_hi_en = 1, m_arr = 0;

  always #2.5 clk = ~clk;

  bank_mapper u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .ram_sel(ram_sel), .ram_page(ram_page), .ram_offset(ram_offset),
    .rom_lo_sel(rom_lo_sel), .rom_hi_sel(rom_hi_sel), .rom_offset(rom_offset),
    .vid_addr(vid_addr), .vid_page(vid_page), .vid_offset(vid_offset)
  );

  function automatic int model_page(int w);
    int p = w;
    if (m_arr == 1 && w == 3) p = 7;
    if (m_arr >= 4 && w == 1) p = m_arr;
    return p;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag_in);
    int w = int'(cpu_addr[15:14]);
    int lo, hi, ram;
    string t;
    lo  = (cpu_rd && !cpu_wr && w == 0 && m_lo_en == 1) ? 1 : 0;
    hi  = (cpu_rd && !cpu_wr && w == 3 && m_hi_en == 1) ? 1 : 0;
    ram = (cpu_wr || (cpu_rd && lo == 0 && hi == 0)) ? 1 : 0;
    t = tag_in;
    if (t == "") begin
      if (cpu_wr) t = "R5";
      else if (!cpu_rd) t = "R11";
      else if (w == 0) t = "R3";
      else if (w == 3) t = (m_arr == 1) ? "R6" : "R4";
      else if (w == 1 && m_arr >= 4) t = "R7";
      else t = "R8";
    end
    chk(t, "ram_sel", int'(ram_sel), ram);
    chk(t, "rom_lo_sel", int'(rom_lo_sel), lo);
    chk(t, "rom_hi_sel", int'(rom_hi_sel), hi);
    chk(t, "ram_page", int'(ram_page), model_page(w));
    chk("R2", "ram_offset", int'(ram_offset), int'(cpu_addr[13:0]));
    chk("R2", "rom_offset", int'(rom_offset), int'(cpu_addr[13:0]));
    chk("R9", "vid_page", int'(vid_page), int'(vid_addr[15:14]));
    chk("R9", "vid_offset", int'(vid_offset), int'(vid_addr[13:0]));
  endtask

  task automatic cycle(input logic we, input logic [7:0] d, input logic [15:0] a,
                       input logic rd, input logic wr, input logic [15:0] va,
                       input string tag);
    @(negedge clk);
    cfg_we = we; cfg_data = d; cpu_addr = a; cpu_rd = rd; cpu_wr = wr; vid_addr = va;
    #1;
    compare(tag);
    @(posedge clk);
    if (we) begin
      m_lo_en = d[0] ? 0 : 1;
      m_hi_en = d[1] ? 0 : 1;
      m_arr   = int'(d[4:2]);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] p_rd;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1: reset state, both ROMs visible, arrangement 0
    cycle(0, 8'h00, 16'h0010, 1, 0, 16'h0000, "R1");
    cycle(0, 8'h00, 16'hC020, 1, 0, 16'h4000, "R1");
    cycle(0, 8'h00, 16'h4444, 1, 0, 16'h8000, "R1");
    // R5: writes under enabled ROMs land in RAM; both strobes -> write
    cycle(0, 8'h00, 16'h0001, 0, 1, 16'hC001, "R5");
    cycle(0, 8'h00, 16'hFFFF, 1, 1, 16'h1234, "R5");
    cycle(0, 8'h00, 16'h8000, 0, 0, 16'h2345, "R11");
    // R10: config write in same cycle as access uses old config
    cycle(1, 8'h07, 16'hC000, 1, 0, 16'hFFFF, "R10");
    cycle(0, 8'h00, 16'hC000, 1, 0, 16'hFFFF, "R10");
    cycle(0, 8'h00, 16'h0100, 1, 0, 16'h0000, "R3");
    cycle(0, 8'h00, 16'hC100, 0, 1, 16'h0000, "R6");
    // R7: arrangements 4..7
    for (int k = 4; k < 8; k++) begin
      cycle(1, 8'((k << 2) | 3), 16'h4000, 1, 0, 16'h7000, "R7");
      cycle(0, 8'h00, 16'h5ABC, 1, 0, 16'h7000, "R7");
      cycle(0, 8'h00, 16'h7FFF, 0, 1, 16'h3000, "R7");
      cycle(0, 8'h00, 16'hC000, 1, 0, 16'h3000, "R7");
    end
    // R8: arrangements 2 and 3 are identity
    cycle(1, 8'h0B, 16'h0000, 0, 0, 16'h0, "R8");
    cycle(0, 8'h00, 16'h4000, 1, 0, 16'h0, "R8");
    cycle(0, 8'h00, 16'hC000, 1, 0, 16'h0, "R8");
    cycle(1, 8'h0C, 16'h4000, 1, 0, 16'h0, "R8");
    cycle(0, 8'h00, 16'h4000, 1, 0, 16'h0, "R8");
    cycle(0, 8'h00, 16'h0000, 1, 0, 16'h0, "R3");
    // R12: both ROMs off, read and write pages agree
    cycle(1, 8'h07, 16'h0000, 0, 0, 16'h0, "R12");
    foreach (p_rd[i]) begin end
    for (int w = 0; w < 4; w++) begin
      @(negedge clk);
      cfg_we = 0; cpu_addr = 16'(w << 14) | 16'h0123; cpu_rd = 1; cpu_wr = 0;
      #1 p_rd = ram_page;
      chk("R12", "read ram_sel", int'(ram_sel), 1);
      cpu_rd = 0; cpu_wr = 1;
      #1 chk("R12", "write page vs read page", int'(ram_page), int'(p_rd));
      @(posedge clk);
    end
    // random phase: all three activities mixed
    for (int n = 0; n < 3000; n++) begin
      logic we;
      logic [1:0] s;
      we = ($urandom % 8) == 0;
      s  = 2'($urandom);
      cycle(we, 8'($urandom), 16'($urandom), s[0], s[1] & s[0] ? 1'b0 : s[1],
            16'($urandom), "");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule